// File: doc/BRIEF.md
# Edge-Triggered Step Sequencer with Re-arm

This block runs a fixed three-step control sequence once for every rising edge seen on an external trigger line. The trigger may come from another clock domain and may be a pulse shorter than one clock period. A small capture flop, clocked by the trigger itself, latches each edge into a level. That level is then brought into the clock domain through a synchroniser and turned into a single-cycle trigger. A state register clocked only by `clk_i` then walks through steps 1, 2 and 3, one step per clock.

After step 3 the machine re-arms. If the trigger is already low, it goes straight back to idle. If the trigger is still high, it parks in a wait-low state until the trigger is sampled low. A trigger that stays high therefore never launches a second run; only a fresh rising edge does. While the machine is not idle, the capture flop is held cleared, so edges that arrive during a run are dropped rather than queued.

Top module: `edge_seq`

## Requirements
- R1: An asserted `rst_i` (active high, asynchronous) forces `step_o` to 0 (idle), `busy_o` low and `done_o` low without waiting for a clock edge, and it discards any captured trigger edge.
- R2: A rising edge on `start_i` while idle starts a run. `step_o` becomes 1 on the third rising `clk_i` edge after the trigger edge: two synchroniser stages plus the state register.
- R3: Once a run has begun, `step_o` advances 1, 2, 3 on consecutive clock edges.
- R4: A `start_i` pulse narrower than one clock period, lying wholly between two clock edges, still launches a full run.
- R5: On leaving step 3 with the synchronised trigger low, `step_o` returns to 0 (idle).
- R6: On leaving step 3 with the synchronised trigger high, `step_o` becomes 4 (wait-low). It holds 4 until the trigger has been sampled low through the two-stage synchroniser, and then moves to 0.
- R7: A trigger held high through and after a run never starts another run. The block leaves wait-low only for idle, and it stays idle until a new rising edge arrives.
- R8: A `start_i` edge that arrives while `step_o` is 1, 2, 3 or 4 has no effect. The run finishes normally, and afterwards `step_o` stays 0 with no second run.
- R9: `busy_o` is high exactly when `step_o` is not 0.
- R10: `done_o` is high for exactly one clock cycle. That cycle is the one right after the step-3 cycle, whether the next state is idle or wait-low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| start_i | input | 1 | Trigger line, may be asynchronous and shorter than a clock period |
| step_o | output | 3 | Current state code: 0 idle, 1..3 steps, 4 wait-low |
| busy_o | output | 1 | High while not idle |
| done_o | output | 1 | One-cycle pulse after step 3 |

## Verification
The hardest cases to reach are those where the trigger level and the machine's own progress overlap in time. One is a trigger that falls during a run, so that the synchronised level at step 3 depends on exactly which edge saw it. Another is an edge that lands mid-run and must not be queued. The stimulus places the trigger's rising edge at a fixed offset from the clock and sweeps its width. Some pulses are sub-cycle and others last several cycles, ending just before or just after the step-3 decision. This puts the machine through both exits from step 3 and through wait-low stays of different lengths. Further directed runs inject a narrow pulse while step 2 is showing, and apply reset while a run is in flight.

// File: rtl/edge_seq_pkg.sv
package edge_seq_pkg;

   localparam int STEP_W = 3;

   typedef enum logic [STEP_W-1:0] {
      ST_IDLE  = 3'd0,
      ST_ONE   = 3'd1,
      ST_TWO   = 3'd2,
      ST_THREE = 3'd3,
      ST_PARK  = 3'd4
   } seq_state_e;

endpackage

// File: rtl/edge_seq_catch.sv
// Edge capture: the only flop clocked by the trigger line. It holds a
// level until the clock domain clears it.
module edge_seq_catch (
   input  logic trig_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge trig_i or posedge clr_i) begin
      if (clr_i) flag_o <= 1'b0;
      else       flag_o <= 1'b1;
   end

endmodule

// File: rtl/edge_seq_sync.sv
// Multi-stage synchroniser for WIDTH independent level signals.
module edge_seq_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_depth
      $error("edge_seq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("edge_seq_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) chain_q[s] <= '0;
            else       chain_q[s] <= d_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) chain_q[s] <= '0;
            else       chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/edge_seq_fsm.sv
// Clock-domain state machine: detects the edge, steps, and re-arms.
module edge_seq_fsm
   import edge_seq_pkg::*;
#(
   parameter bit DONE_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cap_lvl_i,
   input  logic              raw_lvl_i,
   output logic              armed_o,
   output logic [STEP_W-1:0] step_o,
   output logic              busy_o,
   output logic              done_o
);

   seq_state_e state_q, state_d;
   logic       cap_prev_q;
   logic       armed_q;
   logic       trig;

   assign trig = cap_lvl_i & ~cap_prev_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (trig) state_d = ST_ONE;
         ST_ONE:   state_d = ST_TWO;
         ST_TWO:   state_d = ST_THREE;
         ST_THREE: state_d = raw_lvl_i ? ST_PARK : ST_IDLE;
         ST_PARK:  if (!raw_lvl_i) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         state_q    <= ST_IDLE;
         cap_prev_q <= 1'b0;
         armed_q    <= 1'b1;
      end else begin
         state_q    <= state_d;
         cap_prev_q <= cap_lvl_i;
         armed_q    <= (state_d == ST_IDLE);
      end
   end

   if (DONE_REG) begin : g_done_reg
      logic done_q;
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) done_q <= 1'b0;
         else       done_q <= (state_q == ST_THREE);
      end
      assign done_o = done_q;
   end else begin : g_done_comb
      assign done_o = (state_q == ST_THREE) & ~rst_i;
   end

   assign armed_o = armed_q;
   assign step_o  = state_q;
   assign busy_o  = (state_q != ST_IDLE);

endmodule

// File: rtl/edge_seq.sv
module edge_seq
   import edge_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   output logic [STEP_W-1:0] step_o,
   output logic              busy_o,
   output logic              done_o
);

   if (SYNC_STAGES < 2) begin : g_chk_stages
      $error("edge_seq: SYNC_STAGES must be at least 2");
   end

   localparam int LVL_W = 2;

   logic             armed;
   logic             cap_flag;
   logic             cap_clr;
   logic [LVL_W-1:0] lvl_raw;
   logic [LVL_W-1:0] lvl_sync;

   assign cap_clr = rst_i | ~armed;

   edge_seq_catch u_catch (
      .trig_i (start_i),
      .clr_i  (cap_clr),
      .flag_o (cap_flag)
   );

   assign lvl_raw = {start_i, cap_flag};

   edge_seq_sync #(
      .WIDTH  (LVL_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (lvl_raw),
      .q_o   (lvl_sync)
   );

   edge_seq_fsm #(
      .DONE_REG (1'b1)
   ) u_fsm (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .cap_lvl_i (lvl_sync[0]),
      .raw_lvl_i (lvl_sync[1]),
      .armed_o   (armed),
      .step_o    (step_o),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

endmodule

// File: rtl/edge_seq_chk.sv
module edge_seq_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic [2:0] step_o,
   input logic       busy_o,
   input logic       done_o
);

   assert_step_one_two_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_o == 3'd1) |=> (step_o == 3'd2));

   assert_step_two_three_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_o == 3'd2) |=> (step_o == 3'd3));

   assert_done_after_three_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_o == 3'd3) |=> done_o);

   assert_done_single_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);

   assert_park_exit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_o == 3'd4) |=> (step_o == 3'd4 || step_o == 3'd0));

   assert_idle_exit_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_o == 3'd0) |=> (step_o == 3'd0 || step_o == 3'd1));

   assert_busy_rise_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(busy_o) |-> (step_o == 3'd1));

endmodule

bind edge_seq edge_seq_chk u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .step_o (step_o),
   .busy_o (busy_o),
   .done_o (done_o)
);

// File: tb/edge_seq_tb_top.sv
module edge_seq_tb_top;

   localparam int CLK_NS = 10;
   localparam int NVEC   = 6;
   // pulse width in ns, last sample index that still shows wait-low (0: none)
   localparam int VEC_W    [NVEC] = '{3, 7, 25, 35, 45, 100};
   localparam int VEC_LAST [NVEC] = '{0, 0, 0, 6, 7, 12};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [2:0] step;
   logic       busy;
   logic       done;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         finished = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   edge_seq dut_i (
      .clk_i   (clk),
      .rst_i   (rst),
      .start_i (start),
      .step_o  (step),
      .busy_o  (busy),
      .done_o  (done)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic chk_state(input string req, input int exp_step, input int exp_done);
      chk(req, "step", int'(step), exp_step);
      chk("R9", "busy", int'(busy), (exp_step != 0) ? 1 : 0);
      chk("R10", "done", int'(done), exp_done);
   endtask

   task automatic pulse(input int width);
      start = 1'b1;
      fork
         begin
            #(width) start = 1'b0;
         end
      join_none
   endtask

   initial begin
      #(200000 * CLK_NS);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      #(3 * CLK_NS);
      chk_state("R1", 0, 0);
      @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk_state("R1", 0, 0);

      // Table walk: R2, R3, R4, R5, R6, R7
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         #1 pulse(VEC_W[v]);
         for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k < 3)       chk_state((VEC_W[v] < CLK_NS) ? "R4" : "R2", 0, 0);
            else if (k == 3) chk_state("R2", 1, 0);
            else if (k < 6)  chk_state("R3", k - 2, 0);
            else             chk_state((VEC_LAST[v] != 0) ? "R6" : "R5",
                                       (VEC_LAST[v] != 0) ? 4 : 0, 1);
         end
         if (VEC_LAST[v] != 0) begin
            for (int k = 7; k <= VEC_LAST[v]; k++) begin
               @(negedge clk);
               chk_state("R7", 4, 0);
            end
            @(negedge clk);
            chk_state("R6", 0, 0);
         end
         repeat (5) @(negedge clk);
         chk_state("R7", 0, 0);
      end

      // R8: narrow edge while step 2 is showing is dropped
      @(negedge clk);
      #1 pulse(3);
      repeat (4) @(negedge clk);
      chk_state("R3", 2, 0);
      #1 pulse(3);
      @(negedge clk);
      chk_state("R8", 3, 0);
      @(negedge clk);
      chk_state("R8", 0, 1);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk_state("R8", 0, 0);
      end

      // R1: reset mid-run, then a pending edge is discarded
      @(negedge clk);
      #1 pulse(3);
      repeat (4) @(negedge clk);
      chk_state("R3", 2, 0);
      #1 rst = 1'b1;
      #1 chk_state("R1", 0, 0);
      #1 pulse(3);
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk_state("R1", 0, 0);
      end

      // R2 after reset recovery: a fresh edge still works
      #1 pulse(4);
      repeat (3) @(negedge clk);
      chk_state("R2", 1, 0);
      repeat (3) @(negedge clk);
      chk_state("R5", 0, 1);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule